// File: doc/BRIEF.md
# First-Level Translation Table Lookup

This block takes a 32-bit virtual address and a hardware thread number, and returns one of three results. Addresses in the low untranslated window of either half are reported as direct physical mappings. For other addresses, the 4 MiB directory index is checked against a window held per thread. If the index is inside that window, the block fetches one first-level table entry and returns it. If it is outside, the block returns a no-mapping result.

Each thread has two pairs of configuration words: one pair for the local half and one for the global half. Bit 31 of the address chooses the pair. Word 0 of a pair holds the window base and an encoded power-of-two span. Word 1 holds a byte offset to the start of the table. The block accepts one lookup at a time. It registers its range decision and the entry address one cycle after it accepts the request. It then issues at most one read on a simple request/response memory port and raises a one-cycle response.

Top module: `fl_lookup`

## Requirements
- R1: Bit 31 of the address selects the configuration pair: 0 selects the local pair and 1 selects the global pair. The global pair also adds `GLOBAL_OFFSET` to the entry address.
- R2: When address bits [30:27] are all zero, the result is direct. The response carries code 1 and `rsp_data_o` equals the address. No memory read is made. `rsp_valid_o` rises after the second clock edge following acceptance.
- R3: The directory index is address bits [30:22], which is the address with bit 31 cleared, shifted right by 22. The base is config word 0 bits [30:22]. The span is 1 shifted left by word 0 bits [11:8]. The index is in range when base <= index <= base + span, and both bounds are inclusive.
- R4: An out-of-range index gives code 0 with `rsp_data_o` and `rsp_ptr_o` both zero. No memory read is made.
- R5: The entry address is `TABLE_BASE` + thread × `THREAD_STRIDE` + (word 1 & 0x0007FFFC) + (`GLOBAL_OFFSET` when global) + 4 × (index − base).
- R6: For an in-range index, `mem_req_valid_o` rises after the second edge following acceptance. It stays high with a stable address until `mem_req_ready_i` is seen. Exactly one read is made per lookup.
- R7: One cycle after `mem_rsp_valid_i`, the response carries code 2. `rsp_data_o` holds the raw entry and `rsp_ptr_o` holds the entry ANDed with 0xFFFFFFC0.
- R8: `req_ready_o` is high only while idle. `rsp_valid_o` is a single-cycle pulse, and the block is ready again in the following cycle.
- R9: A config write with `cfg_we_i` uses address bits {thread, half, word}. Bit 0 selects the word and bit 1 selects the half (1 = global). All words reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Config write strobe |
| cfg_addr_i | input | TW+2 | Config word select {thread, half, word} |
| cfg_wdata_i | input | 32 | Config write data |
| req_valid_i | input | 1 | Lookup request valid |
| req_ready_o | output | 1 | Lookup request accepted when high |
| req_vaddr_i | input | 32 | Virtual address |
| req_thread_i | input | TW | Hardware thread number |
| mem_req_valid_o | output | 1 | Table read request |
| mem_req_ready_i | input | 1 | Memory accepts the read |
| mem_req_addr_o | output | 32 | Byte address of the first-level entry |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Fetched entry |
| rsp_valid_o | output | 1 | Result pulse |
| rsp_code_o | output | 2 | 0 no mapping, 1 direct, 2 mapped |
| rsp_data_o | output | 32 | Address (direct), raw entry (mapped), or zero |
| rsp_ptr_o | output | 32 | `rsp_data_o` with the low six bits cleared |

## Verification
The properties assume that memory returns exactly one response per accepted read, and only after accepting that read. They also assume that configuration words do not change while a lookup is in flight. The stimulus writes configuration only while the block is idle. It drives `mem_rsp_valid_i` for a single cycle, only after the read handshake, and it varies the accept stall and the return latency. The address patterns are chosen to land exactly on both window bounds and one step outside them, in both halves and on several threads.

// File: rtl/fl_pkg.sv
package fl_pkg;
  localparam int unsigned IDX_LSB = 22;
  localparam int unsigned IDX_W   = 9;
  localparam logic [31:0] OFF_MASK = 32'h0007_FFFC;
  localparam logic [31:0] PTR_MASK = 32'hFFFF_FFC0;

  typedef enum logic [1:0] {
    RES_NONE   = 2'd0,
    RES_DIRECT = 2'd1,
    RES_MAPPED = 2'd2
  } res_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DECODE, ST_ISSUE, ST_WAIT, ST_RESP
  } state_e;
endpackage

// File: rtl/fl_cfg_regs.sv
module fl_cfg_regs #(
  parameter int unsigned NUM_THREADS = 4,
  localparam int unsigned TW = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [TW+1:0] addr_i,
  input  logic [31:0]   wdata_i,
  input  logic [TW-1:0] rd_thread_i,
  input  logic          rd_glb_i,
  output logic [31:0]   cfg0_o,
  output logic [31:0]   cfg1_o
);
  logic [31:0] regs_q [NUM_THREADS][2][2];

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    for (genvar h = 0; h < 2; h++) begin : g_half
      for (genvar w = 0; w < 2; w++) begin : g_word
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) regs_q[t][h][w] <= '0;
          else if (we_i && addr_i[TW+1:2] == TW'(t) && addr_i[1] == 1'(h) && addr_i[0] == 1'(w))
            regs_q[t][h][w] <= wdata_i;
        end
      end
    end
  end

  assign cfg0_o = regs_q[rd_thread_i][rd_glb_i][0];
  assign cfg1_o = regs_q[rd_thread_i][rd_glb_i][1];
endmodule

// File: rtl/fl_decode.sv
module fl_decode
  import fl_pkg::*;
#(
  parameter int unsigned NUM_THREADS   = 4,
  parameter logic [31:0] TABLE_BASE    = 32'h0600_0000,
  parameter logic [31:0] THREAD_STRIDE = 32'h0008_0000,
  parameter logic [31:0] GLOBAL_OFFSET = 32'h0004_0000,
  localparam int unsigned TW = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic [31:0]   vaddr_i,
  input  logic [TW-1:0] thread_i,
  input  logic [31:0]   cfg0_i,
  input  logic [31:0]   cfg1_i,
  output logic          direct_o,
  output logic          in_range_o,
  output logic [31:0]   entry_addr_o
);
  logic             glb;
  logic [IDX_W-1:0] idx, base, diff;
  logic [3:0]       fld;
  logic [16:0]      upper;

  always_comb begin
    glb      = vaddr_i[31];
    // bit 31 is dropped, so both halves share one index space
    idx      = vaddr_i[IDX_LSB +: IDX_W];
    base     = cfg0_i[IDX_LSB +: IDX_W];
    fld      = cfg0_i[11:8];
    upper    = {8'b0, base} + (17'd1 << fld);
    direct_o = (vaddr_i[30:27] == 4'b0);
    in_range_o = (idx >= base) && ({8'b0, idx} <= upper);
    diff     = idx - base;
    entry_addr_o = TABLE_BASE + THREAD_STRIDE * 32'(thread_i) + (cfg1_i & OFF_MASK)
                 + (glb ? GLOBAL_OFFSET : 32'h0) + {21'b0, diff, 2'b00};
  end
endmodule

// File: rtl/fl_ctrl.sv
module fl_ctrl
  import fl_pkg::*;
#(
  parameter int unsigned NUM_THREADS = 4,
  localparam int unsigned TW = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [31:0]   req_vaddr_i,
  input  logic [TW-1:0] req_thread_i,
  output logic [31:0]   vaddr_o,
  output logic [TW-1:0] thread_o,
  input  logic          direct_i,
  input  logic          in_range_i,
  input  logic [31:0]   entry_addr_i,
  output logic          mem_req_valid_o,
  input  logic          mem_req_ready_i,
  output logic [31:0]   mem_req_addr_o,
  input  logic          mem_rsp_valid_i,
  input  logic [31:0]   mem_rsp_data_i,
  output logic          rsp_valid_o,
  output res_e          rsp_code_o,
  output logic [31:0]   rsp_data_o
);
  state_e        state_q;
  logic [31:0]   vaddr_q, addr_q, data_q;
  logic [TW-1:0] thr_q;
  res_e          code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      vaddr_q <= '0;
      thr_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      code_q  <= RES_NONE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          vaddr_q <= req_vaddr_i;
          thr_q   <= req_thread_i;
          state_q <= ST_DECODE;
        end
        ST_DECODE: begin
          addr_q <= entry_addr_i;
          if (direct_i) begin
            code_q  <= RES_DIRECT;
            data_q  <= vaddr_q;
            state_q <= ST_RESP;
          end else if (!in_range_i) begin
            code_q  <= RES_NONE;
            data_q  <= '0;
            state_q <= ST_RESP;
          end else begin
            state_q <= ST_ISSUE;
          end
        end
        ST_ISSUE: if (mem_req_ready_i) state_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid_i) begin
          code_q  <= RES_MAPPED;
          data_q  <= mem_rsp_data_i;
          state_q <= ST_RESP;
        end
        ST_RESP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o     = (state_q == ST_IDLE);
  assign vaddr_o         = vaddr_q;
  assign thread_o        = thr_q;
  assign mem_req_valid_o = (state_q == ST_ISSUE);
  assign mem_req_addr_o  = addr_q;
  assign rsp_valid_o     = (state_q == ST_RESP);
  assign rsp_code_o      = code_q;
  assign rsp_data_o      = data_q;
endmodule

// File: rtl/fl_lookup.sv
module fl_lookup
  import fl_pkg::*;
#(
  parameter int unsigned NUM_THREADS   = 4,
  parameter logic [31:0] TABLE_BASE    = 32'h0600_0000,
  parameter logic [31:0] THREAD_STRIDE = 32'h0008_0000,
  parameter logic [31:0] GLOBAL_OFFSET = 32'h0004_0000,
  localparam int unsigned TW = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [TW+1:0] cfg_addr_i,
  input  logic [31:0]   cfg_wdata_i,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [31:0]   req_vaddr_i,
  input  logic [TW-1:0] req_thread_i,
  output logic          mem_req_valid_o,
  input  logic          mem_req_ready_i,
  output logic [31:0]   mem_req_addr_o,
  input  logic          mem_rsp_valid_i,
  input  logic [31:0]   mem_rsp_data_i,
  output logic          rsp_valid_o,
  output logic [1:0]    rsp_code_o,
  output logic [31:0]   rsp_data_o,
  output logic [31:0]   rsp_ptr_o
);
  logic [31:0]   vaddr, cfg0, cfg1, entry_addr;
  logic [TW-1:0] thread;
  logic          direct, in_range;
  res_e          code;

  fl_cfg_regs #(.NUM_THREADS(NUM_THREADS)) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .rd_thread_i(thread), .rd_glb_i(vaddr[31]),
    .cfg0_o(cfg0), .cfg1_o(cfg1)
  );

  fl_decode #(
    .NUM_THREADS(NUM_THREADS), .TABLE_BASE(TABLE_BASE),
    .THREAD_STRIDE(THREAD_STRIDE), .GLOBAL_OFFSET(GLOBAL_OFFSET)
  ) u_dec (
    .vaddr_i(vaddr), .thread_i(thread), .cfg0_i(cfg0), .cfg1_i(cfg1),
    .direct_o(direct), .in_range_o(in_range), .entry_addr_o(entry_addr)
  );

  fl_ctrl #(.NUM_THREADS(NUM_THREADS)) u_ctrl (
    .clk_i, .rst_ni,
    .req_valid_i, .req_ready_o, .req_vaddr_i, .req_thread_i,
    .vaddr_o(vaddr), .thread_o(thread),
    .direct_i(direct), .in_range_i(in_range), .entry_addr_i(entry_addr),
    .mem_req_valid_o, .mem_req_ready_i, .mem_req_addr_o,
    .mem_rsp_valid_i, .mem_rsp_data_i,
    .rsp_valid_o, .rsp_code_o(code), .rsp_data_o
  );

  assign rsp_code_o = code;
  assign rsp_ptr_o  = rsp_data_o & PTR_MASK;
endmodule

// File: rtl/fl_lookup_chk.sv
module fl_lookup_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic [31:0] req_vaddr_i,
  input logic        mem_req_valid_o,
  input logic        mem_req_ready_i,
  input logic [31:0] mem_req_addr_o,
  input logic        rsp_valid_o,
  input logic [1:0]  rsp_code_o,
  input logic [31:0] rsp_data_o,
  input logic [31:0] rsp_ptr_o
);
  logic [31:0] acc_vaddr;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_vaddr <= '0;
    else if (req_valid_i && req_ready_o) acc_vaddr <= req_vaddr_i;
  end

  // R8
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o && req_ready_o);
  // R8
  busy_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
  // R6
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> mem_req_valid_o && $stable(mem_req_addr_o));
  // R2
  direct_no_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> acc_vaddr[30:27] != 4'b0 && !req_ready_o);
  // R2
  direct_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_code_o == 2'd1) |-> rsp_data_o == acc_vaddr && acc_vaddr[30:27] == 4'b0);
  // R4
  none_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_code_o == 2'd0) |-> rsp_data_o == 32'h0 && rsp_ptr_o == 32'h0);
  // R7
  ptr_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_code_o == 2'd2) |-> rsp_ptr_o == {rsp_data_o[31:6], 6'b0});
endmodule

bind fl_lookup fl_lookup_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_vaddr_i(req_vaddr_i),
  .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
  .mem_req_addr_o(mem_req_addr_o),
  .rsp_valid_o(rsp_valid_o), .rsp_code_o(rsp_code_o),
  .rsp_data_o(rsp_data_o), .rsp_ptr_o(rsp_ptr_o)
);

// File: tb/fl_lookup_tb.sv
module fl_lookup_tb;
  localparam logic [31:0] TB_BASE = 32'h0600_0000;
  localparam logic [31:0] TB_STR  = 32'h0008_0000;
  localparam logic [31:0] TB_GOFF = 32'h0004_0000;

  logic clk = 0, rst_ni = 0;
  always #4 clk = ~clk;

  logic        cfg_we = 0;
  logic [3:0]  cfg_addr = 0;
  logic [31:0] cfg_wdata = 0;
  logic        req_valid = 0, req_ready;
  logic [31:0] req_vaddr = 0;
  logic [1:0]  req_thread = 0;
  logic        mem_req_valid, mem_req_ready = 0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 0;
  logic [31:0] mem_rsp_data = 0;
  logic        rsp_valid;
  logic [1:0]  rsp_code;
  logic [31:0] rsp_data, rsp_ptr;

  fl_lookup #(.NUM_THREADS(4), .TABLE_BASE(TB_BASE), .THREAD_STRIDE(TB_STR),
              .GLOBAL_OFFSET(TB_GOFF)) u_dut (
    .clk_i(clk), .rst_ni,
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_vaddr_i(req_vaddr),
    .req_thread_i(req_thread),
    .mem_req_valid_o(mem_req_valid), .mem_req_ready_i(mem_req_ready),
    .mem_req_addr_o(mem_req_addr),
    .mem_rsp_valid_i(mem_rsp_valid), .mem_rsp_data_i(mem_rsp_data),
    .rsp_valid_o(rsp_valid), .rsp_code_o(rsp_code),
    .rsp_data_o(rsp_data), .rsp_ptr_o(rsp_ptr)
  );

  int tests = 0, fails = 0, reads = 0;
  logic [31:0] cfg_m [4][2][2];

  always @(posedge clk) if (mem_req_valid && mem_req_ready) reads++;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  task automatic wr_cfg(int thr, int glb, int word, logic [31:0] val);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 4'((thr << 2) | (glb << 1) | word); cfg_wdata = val;
    @(negedge clk);
    cfg_we = 0;
    cfg_m[thr][glb][word] = val;
  endtask

  // Reference: code 0 none, 1 direct, 2 mapped; returns entry address
  function automatic int model(logic [31:0] va, int thr, output logic [31:0] addr);
    longint fold, idx, base, up, fld;
    int g;
    g = int'(va[31]);
    fold = longint'(va) & 64'h7FFF_FFFF;
    addr = 0;
    if (fold < 64'h0800_0000) return 1;
    idx  = fold / (64'd1 << 22);
    base = (longint'(cfg_m[thr][g][0]) >> 22) & 64'h1FF;
    fld  = (longint'(cfg_m[thr][g][0]) >> 8) & 64'hF;
    up   = base + (64'd1 << fld);
    if (idx < base || idx > up) return 0;
    addr = 32'(longint'(TB_BASE) + longint'(thr) * longint'(TB_STR)
         + (longint'(cfg_m[thr][g][1]) & 64'h7FFFC) + (g ? longint'(TB_GOFF) : 0)
         + (idx - base) * 4);
    return 2;
  endfunction

  task automatic lookup(string req, logic [31:0] va, int thr, logic [31:0] entry,
                        int stall, int lat);
    logic [31:0] exp_addr;
    int code, r0;
    code = model(va, thr, exp_addr);
    r0 = reads;
    @(negedge clk);
    chk({req, " ready idle"}, 32'(req_ready), 1);
    req_valid = 1; req_vaddr = va; req_thread = 2'(thr);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk({req, " busy"}, 32'(req_ready), 0);
    @(posedge clk);
    @(negedge clk);
    if (code == 2) begin
      chk({req, " R6 read issued"}, 32'(mem_req_valid), 1);
      chk({req, " R5 entry address"}, mem_req_addr, exp_addr);
      for (int i = 0; i < stall; i++) begin
        @(negedge clk);
        chk({req, " R6 hold"}, {31'b0, mem_req_valid}, 1);
        chk({req, " R6 stable addr"}, mem_req_addr, exp_addr);
      end
      mem_req_ready = 1;
      @(posedge clk);
      @(negedge clk);
      mem_req_ready = 0;
      chk({req, " R6 read dropped"}, 32'(mem_req_valid), 0);
      for (int i = 0; i < lat; i++) begin
        @(negedge clk);
        chk({req, " R7 no early rsp"}, 32'(rsp_valid), 0);
      end
      mem_rsp_valid = 1; mem_rsp_data = entry;
      @(posedge clk);
      @(negedge clk);
      mem_rsp_valid = 0;
      chk({req, " R7 rsp valid"}, 32'(rsp_valid), 1);
      chk({req, " R7 code mapped"}, 32'(rsp_code), 2);
      chk({req, " R7 raw entry"}, rsp_data, entry);
      chk({req, " R7 masked ptr"}, rsp_ptr, entry & 32'hFFFF_FFC0);
    end else begin
      chk({req, " R8 rsp valid"}, 32'(rsp_valid), 1);
      chk({req, " code"}, 32'(rsp_code), 32'(code));
      chk({req, " data"}, rsp_data, code == 1 ? va : 32'h0);
      chk({req, " R4 R2 no read"}, 32'(mem_req_valid), 0);
    end
    @(posedge clk);
    @(negedge clk);
    chk({req, " R8 pulse ends"}, 32'(rsp_valid), 0);
    chk({req, " R8 ready again"}, 32'(req_ready), 1);
    chk({req, " R6 read count"}, 32'(reads - r0), code == 2 ? 1 : 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_up();
  end

  initial begin
    for (int t = 0; t < 4; t++)
      for (int h = 0; h < 2; h++)
        for (int w = 0; w < 2; w++) cfg_m[t][h][w] = 0;
    repeat (3) @(negedge clk);
    chk("R8 reset ready", 32'(req_ready), 1);
    chk("R8 reset rsp", 32'(rsp_valid), 0);
    chk("R6 reset read", 32'(mem_req_valid), 0);
    rst_ni = 1;
    // R9 reset-zero config: window 0..1, index 32 is outside
    lookup("R9 R4 reset cfg", 32'h0800_0000, 0, 0, 0, 0);
    // R2 direct windows in both halves
    lookup("R2 local direct", 32'h0000_1234, 0, 0, 0, 0);
    lookup("R2 global direct", 32'h87FF_FFFC, 3, 0, 0, 0);
    // thread 0 local: base 32, span 8 -> 32..40
    wr_cfg(0, 0, 0, (32'd32 << 22) | (32'd3 << 8));
    wr_cfg(0, 0, 1, 32'h0000_1000);
    lookup("R3 R5 mid window", 32'h0940_0000, 0, 32'hDEAD_BEEF, 0, 0);
    lookup("R3 upper bound", 32'h0A00_0000, 0, 32'h1234_567F, 2, 1);
    lookup("R3 R4 above upper", 32'h0A40_0000, 0, 0, 0, 0);
    // thread 1 local: base 64, span 1 -> 64..65
    wr_cfg(1, 0, 0, (32'd64 << 22));
    wr_cfg(1, 0, 1, 32'hFFFF_FFFF);
    lookup("R3 R4 below base", 32'h0FC0_0000, 1, 0, 0, 0);
    lookup("R3 lower bound", 32'h1000_0000, 1, 32'h0000_0041, 0, 3);
    lookup("R5 offset mask", 32'h1040_0000, 1, 32'hFFFF_FFFF, 1, 0);
    // thread 2 global: base 40, span 512 -> 40..552
    wr_cfg(2, 1, 0, (32'd40 << 22) | (32'd9 << 8));
    wr_cfg(2, 1, 1, 32'h0000_0204);
    lookup("R1 global mapped", 32'hC000_0000, 2, 32'hA5A5_A5A5, 3, 2);
    lookup("R1 local pair unset", 32'h4000_0000, 2, 0, 0, 0);
    // thread 3: distinct local and global tables, same folded index
    wr_cfg(3, 0, 0, (32'd100 << 22) | (32'd4 << 8));
    wr_cfg(3, 1, 0, (32'd96 << 22) | (32'd4 << 8));
    wr_cfg(3, 1, 1, 32'h0000_0800);
    lookup("R1 R5 local t3", 32'h1A00_0000, 3, 32'h0000_0FC0, 0, 0);
    lookup("R1 R5 global t3", 32'h9A00_0000, 3, 32'h8000_003F, 0, 1);
    finish_up();
  end
endmodule